// File: doc/BRIEF.md
# PCI Configuration Access Encoder

This block takes one configuration-space access request at a time from a host-side agent and turns it into the values a PCI host bridge places on its configuration engine: a 32-bit address word, a 32-bit command word carrying the active-low byte enables, and write data already moved onto the right byte lanes. Requests target either a remote function (type 0 on bus 0, type 1 behind a bridge) or the host bridge's own local configuration registers. Read data coming back from the target is shifted down to bit 0 and masked to the access size.

A small error status unit records bus-side and system-side error indications reported by the target model, together with the address of the failing access, and software clears each bit by writing a one to it. An access that finds an error pending after its address phase completes as "device not found": a read returns all ones (masked to the size) and a write data phase is not issued. Size and offset pairs that cannot be expressed with byte enables are refused without touching the bus.

The electrical bus cycle is out of scope: the bench acts as the target, answering the address phase with read data and optional error pulses.

Top module: `cfg_access_enc`

## Requirements
- R1: With `req_local`=0 and `req_bus`=0, `bus_addr` is the OR of (1 << `req_dev`), (`req_func` << 8) and `req_off` with bits 1:0 cleared.
- R2: With `req_local`=0 and `req_bus`≠0, `bus_addr` = `req_bus`<<16 | `req_dev`<<11 | `req_func`<<8 | (`req_off` & ~3) | 1.
- R3: Byte enables are active low and depend on `req_size` (1, 2 or 4 bytes) and `req_off[1:0]`: size 1 at lane 0,1,2,3 gives 0xE,0xD,0xB,0x7; size 2 at lane 0 gives 0xC, at lane 2 gives 0x3; size 4 at lane 0 gives 0x0. Any other pair (including sizes other than 1, 2, 4) completes with `done` and `rsp_illegal` one cycle after acceptance and no `bus_cmd_valid`.
- R4: For a remote access, `bus_cmd` holds the byte enables in bits 7:4, the code 0xA (read) or 0xB (write) in bits 3:0, and zero elsewhere.
- R5: For a local access, `bus_cmd` holds the byte enables in bits 23:20, bit 16 set for a write and clear for a read, `req_off` with bits 1:0 cleared in the low bits, and zero elsewhere; `bus_addr` equals that aligned offset.
- R6: For a write with no error, `bus_wr_valid` pulses for one cycle, the cycle after `bus_cmd_valid`, with `bus_wdata` = `req_wdata` << (8·`req_off[1:0]`).
- R7: For a read with no error, `rsp_rdata` = (`bus_rdata` sampled the cycle after `bus_cmd_valid`) >> (8·`req_off[1:0]`), masked to 0xFF, 0xFFFF or 0xFFFFFFFF for size 1, 2, 4.
- R8: A pulse on `tgt_pci_err` bits sets the matching `pci_err_stat` bits and captures `tgt_err_addr` into `pci_err_addr`; `tgt_ahb_err` does the same for `ahb_err_stat`/`ahb_err_addr`. With `err_clr_we`, ones in `err_clr_pci`/`err_clr_ahb` clear the bits; a set in the same cycle wins.
- R9: If any status bit is set in the cycle after the address phase, the access completes with `rsp_notfound`=1, `bus_wr_valid` stays low, and a read returns all ones shifted and masked as in R7.
- R10: `req_valid` is accepted only while `busy` is low; a legal access raises `bus_cmd_valid` for exactly the cycle after acceptance and `done` for one cycle three cycles after acceptance, with `busy` high in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an access (taken when not busy) |
| req_local | input | 1 | 1 = host bridge's own registers |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_wdata | input | 32 | Write data, right aligned |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Aligned, masked read data |
| rsp_notfound | output | 1 | Completion saw a pending error |
| rsp_illegal | output | 1 | Completion refused a size/offset pair |
| bus_cmd_valid | output | 1 | Address phase strobe |
| bus_addr | output | 32 | Configuration address word |
| bus_cmd | output | 32 | Command word with byte enables |
| bus_wr_valid | output | 1 | Write data phase strobe |
| bus_wdata | output | 32 | Lane-shifted write data |
| bus_rdata | input | 32 | Target read data |
| tgt_pci_err | input | 2 | Bus-side error set pulses |
| tgt_ahb_err | input | 1 | System-side error set pulse |
| tgt_err_addr | input | 32 | Address of the failing access |
| err_clr_we | input | 1 | Status clear strobe |
| err_clr_pci | input | 2 | Write-one-to-clear mask, bus-side |
| err_clr_ahb | input | 1 | Write-one-to-clear mask, system-side |
| pci_err_stat | output | 2 | Bus-side error status |
| pci_err_addr | output | 32 | Captured bus-side error address |
| ahb_err_stat | output | 1 | System-side error status |
| ahb_err_addr | output | 32 | Captured system-side error address |

## Verification
Random accesses mix bus zero against nonzero buses and local against remote targets, so a wrong type 0/type 1 choice or a byte enable in the wrong command field shows as an address or command miscompare. Sizes and offsets are drawn across all lanes, including unaligned and unsupported pairs, which separates a lane shift error from a mask error and proves that refused pairs never reach the bus. Directed cases inject errors on both status paths, leave one pending across a later access, and clear with a simultaneous set, distinguishing write-one-to-clear from set priority and suppressed writes from issued ones.

// File: rtl/cfg_enc_pkg.sv
// Package: shared state type, field positions and the byte-enable decode
// used by the configuration access encoder.
// Assumes 32-bit data with four byte lanes.
package cfg_enc_pkg;
    localparam int DATA_W        = 32;
    localparam int LANES         = DATA_W / 8;
    localparam int REMOTE_BE_LSB = 4;
    localparam int LOCAL_BE_LSB  = 20;
    localparam int LOCAL_WR_BIT  = 16;
    localparam logic [3:0] CODE_RD = 4'hA;
    localparam logic [3:0] CODE_WR = 4'hB;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RESP} seq_e;

    typedef struct packed {
        logic       bad;
        logic [3:0] be_n;
    } lane_sel_t;

    // Active-low byte enables for a size/offset pair, with illegal flag.
    function automatic lane_sel_t lane_enables(input logic [2:0] size,
                                               input logic [1:0] lo);
        lane_sel_t r;
        r.bad  = 1'b0;
        r.be_n = 4'hF;
        case (size)
            3'd1: r.be_n = ~(4'b0001 << lo);
            3'd2: if (!lo[0]) r.be_n = lo[1] ? 4'h3 : 4'hC;
                  else        r.bad  = 1'b1;
            3'd4: if (lo == 2'd0) r.be_n = 4'h0;
                  else            r.bad  = 1'b1;
            default: r.bad = 1'b1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cfg_addr_form.sv
// Module: forms the address and command words of one configuration access.
// Purely combinational; assumes the size/offset pair was checked legal.
module cfg_addr_form
    import cfg_enc_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3,
    parameter int OFF_W  = 8
) (
    input  logic              is_local,
    input  logic              is_write,
    input  logic [BUS_W-1:0]  bus_no,
    input  logic [DEV_W-1:0]  dev_no,
    input  logic [FUNC_W-1:0] func_no,
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        size,
    output logic [DATA_W-1:0] addr_word,
    output logic [DATA_W-1:0] cmd_word
);
    logic [DATA_W-1:0] off_al;
    lane_sel_t         sel;

    // Select the word-aligned offset and the lane enables.
    always_comb begin
        off_al = DATA_W'({offset[OFF_W-1:2], 2'b00});
        sel    = lane_enables(size, offset[1:0]);
    end

    // Build type 0, type 1 or local address and the matching command.
    always_comb begin
        if (is_local) begin
            addr_word = off_al;
            cmd_word  = (DATA_W'(sel.be_n) << LOCAL_BE_LSB) | off_al;
            cmd_word[LOCAL_WR_BIT] = is_write;
        end else begin
            if (bus_no == '0)
                addr_word = (DATA_W'(1) << dev_no) | (DATA_W'(func_no) << 8) | off_al;
            else
                addr_word = (DATA_W'(bus_no) << 16) | (DATA_W'(dev_no) << 11)
                          | (DATA_W'(func_no) << 8) | off_al | DATA_W'(1);
            cmd_word = (DATA_W'(sel.be_n) << REMOTE_BE_LSB)
                     | DATA_W'(is_write ? CODE_WR : CODE_RD);
        end
    end
endmodule

// File: rtl/cfg_lane_align.sv
// Module: moves write data up onto its byte lanes and brings read data
// down to bit 0, masked to the access size. Combinational.
// Assumes sizes 1, 2, 4; other sizes give a zero mask.
module cfg_lane_align
    import cfg_enc_pkg::*;
(
    input  logic [1:0]        lo,
    input  logic [2:0]        size,
    input  logic              force_ones,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] src;
    logic [4:0]        sh;

    // Shift amount, size mask and read source (all ones on error).
    always_comb begin
        sh  = {lo, 3'b000};
        src = force_ones ? '1 : rdata_in;
        case (size)
            3'd1:    mask = DATA_W'(8'hFF);
            3'd2:    mask = DATA_W'(16'hFFFF);
            3'd4:    mask = '1;
            default: mask = '0;
        endcase
    end

    // Apply the lane shifts.
    always_comb begin
        wdata_out = wdata_in << sh;
        rdata_out = (src >> sh) & mask;
    end
endmodule

// File: rtl/cfg_err_status.sv
// Module: error status bits with captured addresses, write-one-to-clear.
// A set pulse in the same cycle as a clear keeps the bit set.
module cfg_err_status
    import cfg_enc_pkg::*;
#(
    parameter int PERR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PERR_W-1:0] set_pci,
    input  logic              set_ahb,
    input  logic [DATA_W-1:0] set_addr,
    input  logic              clr_we,
    input  logic [PERR_W-1:0] clr_pci,
    input  logic              clr_ahb,
    output logic [PERR_W-1:0] pci_stat,
    output logic [DATA_W-1:0] pci_addr,
    output logic              ahb_stat,
    output logic [DATA_W-1:0] ahb_addr
);
    // Bus-side status and address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_stat <= '0;
            pci_addr <= '0;
        end else begin
            pci_stat <= (pci_stat & ~(clr_we ? clr_pci : '0)) | set_pci;
            if (|set_pci) pci_addr <= set_addr;
        end
    end

    // System-side status and address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ahb_stat <= 1'b0;
            ahb_addr <= '0;
        end else begin
            ahb_stat <= (ahb_stat & ~(clr_we & clr_ahb)) | set_ahb;
            if (set_ahb) ahb_addr <= set_addr;
        end
    end
endmodule

// File: rtl/cfg_access_enc.sv
// Top: accepts one configuration access at a time, refuses illegal
// size/offset pairs, issues the address phase, then completes with read
// data or a suppressed write when an error is pending.
// Assumes the target answers in the cycle after the address phase.
module cfg_access_enc
    import cfg_enc_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3,
    parameter int OFF_W  = 8,
    parameter int PERR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_local,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_notfound,
    output logic              rsp_illegal,
    output logic              bus_cmd_valid,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_cmd,
    output logic              bus_wr_valid,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic [PERR_W-1:0] tgt_pci_err,
    input  logic              tgt_ahb_err,
    input  logic [31:0]       tgt_err_addr,
    input  logic              err_clr_we,
    input  logic [PERR_W-1:0] err_clr_pci,
    input  logic              err_clr_ahb,
    output logic [PERR_W-1:0] pci_err_stat,
    output logic [31:0]       pci_err_addr,
    output logic              ahb_err_stat,
    output logic [31:0]       ahb_err_addr
);
    seq_e              st;
    logic              q_local, q_write;
    logic [BUS_W-1:0]  q_bus;
    logic [DEV_W-1:0]  q_dev;
    logic [FUNC_W-1:0] q_func;
    logic [OFF_W-1:0]  q_off;
    logic [2:0]        q_size;
    logic [31:0]       q_wdata;
    logic              err_any;
    logic [31:0]       rd_aligned;
    lane_sel_t         in_sel;

    cfg_addr_form #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W)) u_form (
        .is_local(q_local), .is_write(q_write), .bus_no(q_bus), .dev_no(q_dev),
        .func_no(q_func), .offset(q_off), .size(q_size),
        .addr_word(bus_addr), .cmd_word(bus_cmd)
    );

    cfg_lane_align u_align (
        .lo(q_off[1:0]), .size(q_size), .force_ones(err_any),
        .wdata_in(q_wdata), .rdata_in(bus_rdata),
        .wdata_out(bus_wdata), .rdata_out(rd_aligned)
    );

    cfg_err_status #(.PERR_W(PERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .set_pci(tgt_pci_err), .set_ahb(tgt_ahb_err),
        .set_addr(tgt_err_addr), .clr_we(err_clr_we), .clr_pci(err_clr_pci),
        .clr_ahb(err_clr_ahb), .pci_stat(pci_err_stat), .pci_addr(pci_err_addr),
        .ahb_stat(ahb_err_stat), .ahb_addr(ahb_err_addr)
    );

    // Decode legality of the incoming request and the pending error.
    always_comb begin
        in_sel  = lane_enables(req_size, req_off[1:0]);
        err_any = (|pci_err_stat) | ahb_err_stat;
    end

    // Bus strobes and busy derived from the sequencer state.
    always_comb begin
        busy          = (st != ST_IDLE);
        bus_cmd_valid = (st == ST_ISSUE);
        bus_wr_valid  = (st == ST_RESP) && q_write && !err_any;
    end

    // Sequencer: accept, issue the address phase, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            done         <= 1'b0;
            rsp_notfound <= 1'b0;
            rsp_illegal  <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            done         <= 1'b0;
            rsp_notfound <= 1'b0;
            rsp_illegal  <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    if (in_sel.bad) begin
                        done        <= 1'b1;
                        rsp_illegal <= 1'b1;
                    end else begin
                        st <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_RESP;
                default: begin
                    st           <= ST_IDLE;
                    done         <= 1'b1;
                    rsp_notfound <= err_any;
                    if (!q_write) rsp_rdata <= rd_aligned;
                end
            endcase
        end
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_local <= 1'b0;
            q_write <= 1'b0;
            q_bus   <= '0;
            q_dev   <= '0;
            q_func  <= '0;
            q_off   <= '0;
            q_size  <= 3'd4;
            q_wdata <= '0;
        end else if (st == ST_IDLE && req_valid) begin
            q_local <= req_local;
            q_write <= req_write;
            q_bus   <= req_bus;
            q_dev   <= req_dev;
            q_func  <= req_func;
            q_off   <= req_off;
            q_size  <= req_size;
            q_wdata <= req_wdata;
        end
    end
endmodule

// File: rtl/cfg_access_enc_chk.sv
// Checker: temporal properties of the configuration access encoder,
// attached to every instance of the top through bind.
module cfg_access_enc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       rsp_notfound,
    input logic       rsp_illegal,
    input logic       bus_cmd_valid,
    input logic       bus_wr_valid,
    input logic [1:0] tgt_pci_err,
    input logic       err_clr_we,
    input logic [1:0] err_clr_pci,
    input logic [1:0] pci_err_stat
);
    // R10
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |=> !bus_cmd_valid);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (done && !rsp_notfound));
    // R6
    wr_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_valid |-> $past(bus_cmd_valid));
    // R9
    notfound_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_notfound |-> done);
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_we && err_clr_pci == 2'b11 && tgt_pci_err == 2'b00) |=> pci_err_stat == 2'b00);
endmodule

bind cfg_access_enc cfg_access_enc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .rsp_notfound(rsp_notfound), .rsp_illegal(rsp_illegal),
    .bus_cmd_valid(bus_cmd_valid), .bus_wr_valid(bus_wr_valid),
    .tgt_pci_err(tgt_pci_err), .err_clr_we(err_clr_we),
    .err_clr_pci(err_clr_pci), .pci_err_stat(pci_err_stat)
);

// File: tb/sim_cfg_access_enc.sv
`timescale 1ns/1ps
module sim_cfg_access_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_local = 0, req_write = 0;
    logic [7:0]  req_bus = 0;
    logic [4:0]  req_dev = 0;
    logic [2:0]  req_func = 0;
    logic [7:0]  req_off = 0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = 0;
    logic        busy, done, rsp_notfound, rsp_illegal;
    logic [31:0] rsp_rdata;
    logic        bus_cmd_valid, bus_wr_valid;
    logic [31:0] bus_addr, bus_cmd, bus_wdata;
    logic [31:0] bus_rdata = 0;
    logic [1:0]  tgt_pci_err = 0;
    logic        tgt_ahb_err = 0;
    logic [31:0] tgt_err_addr = 0;
    logic        err_clr_we = 0;
    logic [1:0]  err_clr_pci = 0;
    logic        err_clr_ahb = 0;
    logic [1:0]  pci_err_stat;
    logic [31:0] pci_err_addr, ahb_err_addr;
    logic        ahb_err_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit pend = 0;

    always #2.5 clk = ~clk;

    cfg_access_enc u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected active-low byte enables; bit 4 flags an illegal pair.
    function automatic logic [4:0] exp_be(input logic [2:0] sz, input logic [1:0] lo);
        if (sz == 3'd1 && lo == 0) return 5'h0E;
        if (sz == 3'd1 && lo == 1) return 5'h0D;
        if (sz == 3'd1 && lo == 2) return 5'h0B;
        if (sz == 3'd1 && lo == 3) return 5'h07;
        if (sz == 3'd2 && lo == 0) return 5'h0C;
        if (sz == 3'd2 && lo == 2) return 5'h03;
        if (sz == 3'd4 && lo == 0) return 5'h00;
        return 5'h1F;
    endfunction

    function automatic logic [31:0] exp_addr(input bit loc, input logic [7:0] b,
            input logic [4:0] d, input logic [2:0] f, input logic [7:0] o);
        logic [31:0] oa = {24'd0, o[7:2], 2'b00};
        if (loc) return oa;
        if (b == 0) return (32'd1 << d) | ({29'd0, f} << 8) | oa;
        return ({24'd0, b} << 16) | ({27'd0, d} << 11) | ({29'd0, f} << 8) | oa | 32'd1;
    endfunction

    function automatic logic [31:0] exp_cmd(input bit loc, input bit wr,
            input logic [7:0] o, input logic [3:0] be);
        if (loc) return ({28'd0, be} << 20) | (wr ? 32'h0001_0000 : 32'h0) | {24'd0, o[7:2], 2'b00};
        return ({28'd0, be} << 4) | (wr ? 32'hB : 32'hA);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] w, input logic [2:0] sz,
                                           input logic [1:0] lo);
        logic [31:0] m = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        return (w >> (8 * lo)) & m;
    endfunction

    // One access; inj: 0 none, 1 bus-side error, 2 system-side error.
    task automatic access(input bit loc, input bit wr, input logic [7:0] b,
            input logic [4:0] d, input logic [2:0] f, input logic [7:0] o,
            input logic [2:0] sz, input logic [31:0] wd, input logic [31:0] tword,
            input int inj);
        logic [4:0] be = exp_be(sz, o[1:0]);
        bit nf;
        chk(busy == 0, "R10", "idle before request", {31'd0, busy}, 0);
        req_valid = 1; req_local = loc; req_write = wr; req_bus = b; req_dev = d;
        req_func = f; req_off = o; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (be[4]) begin
            chk(done && rsp_illegal && !bus_cmd_valid, "R3", "illegal refused",
                {29'd0, done, rsp_illegal, bus_cmd_valid}, 32'h6);
            @(negedge clk);
            chk(!bus_cmd_valid, "R3", "no command after refusal", {31'd0, bus_cmd_valid}, 0);
            return;
        end
        chk(bus_cmd_valid && busy, "R10", "address phase", {30'd0, bus_cmd_valid, busy}, 3);
        chk(bus_addr == exp_addr(loc, b, d, f, o), (loc || b == 0) ? (loc ? "R5" : "R1") : "R2",
            "address word", bus_addr, exp_addr(loc, b, d, f, o));
        chk(bus_cmd == exp_cmd(loc, wr, o, be[3:0]), loc ? "R5" : "R4", "command word",
            bus_cmd, exp_cmd(loc, wr, o, be[3:0]));
        bus_rdata = tword;
        tgt_err_addr = bus_addr;
        tgt_pci_err = (inj == 1) ? 2'b01 : 2'b00;
        tgt_ahb_err = (inj == 2);
        nf = pend || (inj != 0);
        // Request offered while busy must be ignored (R10).
        req_valid = 1; req_size = 3'd4; req_off = 8'h10;
        @(negedge clk);
        tgt_pci_err = 0; tgt_ahb_err = 0; req_valid = 0;
        chk(bus_wr_valid == (wr && !nf), nf ? "R9" : "R6", "write phase strobe",
            {31'd0, bus_wr_valid}, {31'd0, wr && !nf});
        if (wr && !nf)
            chk(bus_wdata == (wd << (8 * o[1:0])), "R6", "lane-shifted write data",
                bus_wdata, wd << (8 * o[1:0]));
        chk(done == 0, "R10", "no early done", {31'd0, done}, 0);
        @(negedge clk);
        chk(done && rsp_notfound == nf, nf ? "R9" : "R10", "completion",
            {30'd0, done, rsp_notfound}, {30'd0, 1'b1, nf});
        if (!wr)
            chk(rsp_rdata == exp_rd(nf ? 32'hFFFF_FFFF : tword, sz, o[1:0]), nf ? "R9" : "R7",
                "read data", rsp_rdata, exp_rd(nf ? 32'hFFFF_FFFF : tword, sz, o[1:0]));
        if (inj == 1) chk(pci_err_stat[0] && pci_err_addr == exp_addr(loc, b, d, f, o), "R8",
            "bus-side capture", pci_err_addr, exp_addr(loc, b, d, f, o));
        if (inj == 2) chk(ahb_err_stat && ahb_err_addr == exp_addr(loc, b, d, f, o), "R8",
            "system-side capture", ahb_err_addr, exp_addr(loc, b, d, f, o));
        if (inj != 0) pend = 1;
        @(negedge clk);
        chk(!bus_cmd_valid && !busy, "R10", "busy request ignored",
            {30'd0, bus_cmd_valid, busy}, 0);
    endtask

    task automatic clear_all();
        err_clr_we = 1; err_clr_pci = 2'b11; err_clr_ahb = 1;
        @(negedge clk);
        err_clr_we = 0; err_clr_pci = 0; err_clr_ahb = 0;
        chk(pci_err_stat == 0 && !ahb_err_stat, "R8", "write-one-to-clear",
            {29'd0, ahb_err_stat, pci_err_stat}, 0);
        pend = 0;
    endtask

    initial begin
        int sd;
        sd = $urandom(32'd7301);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_cmd_valid && pci_err_stat == 0 && !ahb_err_stat,
            "R10", "reset state", {27'd0, busy, done, bus_cmd_valid, pci_err_stat}, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed corners.
        access(0, 0, 8'd0, 5'd31, 3'd7, 8'hFC, 3'd4, 0, 32'hA1B2_C3D4, 0);  // R1
        access(0, 1, 8'd0, 5'd11, 3'd2, 8'h43, 3'd1, 32'h5A, 0, 0);         // R1 R6
        access(0, 0, 8'd255, 5'd5, 3'd1, 8'h06, 3'd2, 0, 32'h1234_5678, 0); // R2 R7
        access(1, 1, 8'd0, 5'd0, 3'd0, 8'h04, 3'd4, 32'h0000_0157, 0, 0);   // R5
        access(1, 0, 8'd0, 5'd0, 3'd0, 8'h3D, 3'd1, 0, 32'hCAFE_F00D, 0);   // R5 R7
        access(0, 0, 8'd1, 5'd1, 3'd0, 8'h01, 3'd2, 0, 0, 0);               // R3 odd half
        access(0, 1, 8'd1, 5'd1, 3'd0, 8'h02, 3'd4, 0, 0, 0);               // R3 unaligned word
        access(0, 0, 8'd1, 5'd1, 3'd0, 8'h00, 3'd3, 0, 0, 0);               // R3 bad size
        access(0, 1, 8'd2, 5'd3, 3'd1, 8'h08, 3'd4, 32'h1111_2222, 0, 1);   // R9 write suppressed
        access(0, 0, 8'd0, 5'd4, 3'd0, 8'h0B, 3'd1, 0, 32'h7788_99AA, 0);   // R9 still pending
        // R8: clear bit0 while bit1 is set in the same cycle.
        err_clr_we = 1; err_clr_pci = 2'b11; tgt_pci_err = 2'b10;
        @(negedge clk);
        err_clr_we = 0; err_clr_pci = 0; tgt_pci_err = 0;
        chk(pci_err_stat == 2'b10, "R8", "set wins over clear", {30'd0, pci_err_stat}, 2);
        clear_all();
        access(1, 0, 8'd0, 5'd0, 3'd0, 8'h02, 3'd2, 0, 32'h0BAD_BEEF, 2);   // R9 system-side
        clear_all();
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sz;
            logic [7:0] o;
            int pick = $urandom % 10;
            int inj = ($urandom % 8 == 0) ? 1 + ($urandom % 2) : 0;
            sz = (pick < 3) ? 3'd1 : (pick < 6) ? 3'd2 : (pick < 9) ? 3'd4 : 3'($urandom % 8);
            o = 8'($urandom);
            if ($urandom % 4 != 0) o = (sz == 2) ? {o[7:1], 1'b0} : (sz == 4) ? {o[7:2], 2'b00} : o;
            access($urandom % 4 == 0, 1'($urandom), ($urandom % 2) ? 8'd0 : 8'($urandom),
                   5'($urandom), 3'($urandom), o, sz, $urandom, $urandom, inj);
            if (pend) clear_all();
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule